// File: doc/BRIEF.md
# Time-Multiplexed Stereo Amplitude Mixer

This block feeds two external 6-bit resistor DACs, a left one and a right one, from four sound sources: three square-wave tones and one noise stream. Instead of adding the sources digitally, it gives each source its own time slot. A 2-bit slot counter steps through the sources each time the slot strobe is asserted. In each slot, each side shows that source's amplitude when the source's waveform bit is high, and shows zero when it is low. The slot sequence is the same for both sides.

Each side has four 6-bit amplitude registers, so there are eight in total. They are loaded through a simple indexed write port. A per-side mode bit turns that side into a plain 6-bit DAC, which continuously outputs the side's tone-0 amplitude register and ignores the waveform inputs. The side outputs are registered and change only at slot boundaries. A register write therefore becomes visible at the next boundary and never in the middle of a slot. The analog network and any smoothing lie outside this block.

Top module: `stereo_slot_mixer`

## Requirements
- R1: A synchronous active-high reset clears all eight amplitude registers, drives both side outputs to zero and sets the slot index to 0.
- R2: Each cycle with `slot_adv` high advances the slot index by one: 0 tone 0, 1 tone 1, 2 tone 2, 3 noise, then back to 0. Without `slot_adv` the index holds.
- R3: A write with `wr_en` high and `wr_idx` 8, 9, 10 or 11 loads the left amplitude for source `wr_idx`-8. Indices 12 to 15 load the right amplitude for source `wr_idx`-12. Source numbering matches `src_bits`: bit 0 tone 0, bit 1 tone 1, bit 2 tone 2, bit 3 noise.
- R4: Writes to indices 0 to 7 change no amplitude register.
- R5: At a boundary into slot k, a side not in DAC mode outputs its amplitude register for source k when `src_bits[k]` is high in that cycle.
- R6: At a boundary into slot k, a side not in DAC mode outputs zero when `src_bits[k]` is low.
- R7: `dac_mode[0]` (left) and `dac_mode[1]` (right) make that side output its source-0 amplitude register at every boundary, whatever `src_bits` holds.
- R8: Side outputs change only in cycles with `slot_adv` high (or reset). A write shows no effect before the next boundary. A write in the same cycle as a boundary takes effect at the boundary after it.
- R9: Only bits 5 to 0 of `wr_data` are stored; bits 7 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_adv | input | 1 | Slot boundary strobe |
| src_bits | input | 4 | Waveform bits: tone 0, tone 1, tone 2, noise (bit 0 to 3) |
| dac_mode | input | 2 | Plain-DAC mode per side, bit 0 left, bit 1 right |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register index, 8 to 15 used |
| wr_data | input | 8 | Write data, amplitude in bits 5 to 0 |
| left_level | output | 6 | Left DAC code |
| right_level | output | 6 | Right DAC code |
| slot_idx | output | 2 | Source index shown in the current slot |

## Verification
Every result has a latency of exactly one clock edge. `slot_idx` and both levels take their new values at the same rising edge that sees `slot_adv`, built from the `src_bits`, `dac_mode` and register contents present before that edge. A write is stored at its own edge but reaches an output only at a later boundary. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge, using the values held before that edge. It compares all three outputs at the next falling edge, on every clock, so a value that arrives a cycle early or late is caught.

// File: rtl/mix_pkg.sv
package mix_pkg;
    localparam int MIX_AMP_W  = 6;
    localparam int MIX_NSRC   = 4;
    localparam int MIX_ADDR_W = 4;
    localparam int MIX_DATA_W = 8;
    localparam int MIX_LBASE  = 8;

    typedef enum logic [1:0] {
        SRC_TONE0 = 2'd0,
        SRC_TONE1 = 2'd1,
        SRC_TONE2 = 2'd2,
        SRC_NOISE = 2'd3
    } src_e;

    typedef enum int {SIDE_LEFT = 0, SIDE_RIGHT = 1} side_e;

    function automatic int wrap_inc(input int cur, input int n);
        return (cur == n - 1) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/mix_slot_counter.sv
module mix_slot_counter #(
    parameter int NUM_SRC = mix_pkg::MIX_NSRC,
    localparam int SLOT_W = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_nxt
);
    always_comb slot_nxt = SLOT_W'(mix_pkg::wrap_inc(int'(slot_q), NUM_SRC));

    always_ff @(posedge clk) begin
        if (rst)      slot_q <= '0;
        else if (adv) slot_q <= slot_nxt;
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        adv && (slot_q == SLOT_W'(NUM_SRC - 1)) |=> slot_q == '0); // R2
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(slot_q)); // R2
endmodule

// File: rtl/mix_amp_bank.sv
module mix_amp_bank #(
    parameter int AMP_W   = mix_pkg::MIX_AMP_W,
    parameter int NUM_SRC = mix_pkg::MIX_NSRC,
    parameter int ADDR_W  = mix_pkg::MIX_ADDR_W,
    parameter int BASE    = mix_pkg::MIX_LBASE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_idx,
    input  logic [AMP_W-1:0]         wr_amp,
    output logic [NUM_SRC*AMP_W-1:0] amps
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_reg
        logic             hit;
        logic [AMP_W-1:0] amp_q;
        assign hit = wr_en && (wr_idx == ADDR_W'(BASE + i));

        always_ff @(posedge clk) begin
            if (rst)      amp_q <= '0;
            else if (hit) amp_q <= wr_amp;
        end
        assign amps[i*AMP_W +: AMP_W] = amp_q;

        AST_REG_KEEP: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == ADDR_W'(BASE + i)) |=> $stable(amps[i*AMP_W +: AMP_W])); // R4
    end

    AST_BANK_CLEAR: assert property (@(posedge clk)
        rst |=> amps == '0); // R1
endmodule

// File: rtl/mix_side_sel.sv
module mix_side_sel #(
    parameter int AMP_W   = mix_pkg::MIX_AMP_W,
    parameter int NUM_SRC = mix_pkg::MIX_NSRC,
    localparam int SLOT_W = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic                     dac_mode,
    input  logic [NUM_SRC-1:0]       src_bits,
    input  logic [SLOT_W-1:0]        slot_nxt,
    input  logic [NUM_SRC*AMP_W-1:0] amps,
    output logic [AMP_W-1:0]         level
);
    logic [AMP_W-1:0] sel_amp;
    logic             sel_bit;
    logic [AMP_W-1:0] level_d;

    always_comb begin
        sel_amp = amps[slot_nxt*AMP_W +: AMP_W];
        sel_bit = src_bits[slot_nxt];
        if (dac_mode)     level_d = amps[AMP_W-1:0];
        else if (sel_bit) level_d = sel_amp;
        else              level_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)      level <= '0;
        else if (adv) level <= level_d;
    end

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(level)); // R8
    AST_DAC_DIRECT: assert property (@(posedge clk) disable iff (rst)
        adv && dac_mode |=> level == $past(amps[AMP_W-1:0])); // R7
    AST_SRC_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        adv && !dac_mode && !src_bits[slot_nxt] |=> level == '0); // R6
    AST_LEVEL_CLEAR: assert property (@(posedge clk)
        rst |=> level == '0); // R1
endmodule

// File: rtl/stereo_slot_mixer.sv
module stereo_slot_mixer #(
    parameter int AMP_W     = mix_pkg::MIX_AMP_W,
    parameter int NUM_SRC   = mix_pkg::MIX_NSRC,
    parameter int ADDR_W    = mix_pkg::MIX_ADDR_W,
    parameter int DATA_W    = mix_pkg::MIX_DATA_W,
    parameter int LEFT_BASE = mix_pkg::MIX_LBASE,
    localparam int SLOT_W   = $clog2(NUM_SRC),
    localparam int NUM_SIDE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_adv,
    input  logic [NUM_SRC-1:0] src_bits,
    input  logic [1:0]         dac_mode,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [AMP_W-1:0]   left_level,
    output logic [AMP_W-1:0]   right_level,
    output logic [SLOT_W-1:0]  slot_idx
);
    logic [SLOT_W-1:0] slot_nxt;
    logic [AMP_W-1:0]  side_level [NUM_SIDE];
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:AMP_W];

    mix_slot_counter #(.NUM_SRC(NUM_SRC)) u_slot (
        .clk(clk), .rst(rst), .adv(slot_adv),
        .slot_q(slot_idx), .slot_nxt(slot_nxt)
    );

    for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
        logic [NUM_SRC*AMP_W-1:0] amps;

        mix_amp_bank #(
            .AMP_W(AMP_W), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
            .BASE(LEFT_BASE + s * NUM_SRC)
        ) u_bank (
            .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
            .wr_amp(wr_data[AMP_W-1:0]), .amps(amps)
        );

        mix_side_sel #(.AMP_W(AMP_W), .NUM_SRC(NUM_SRC)) u_sel (
            .clk(clk), .rst(rst), .adv(slot_adv), .dac_mode(dac_mode[s]),
            .src_bits(src_bits), .slot_nxt(slot_nxt), .amps(amps),
            .level(side_level[s])
        );
    end

    assign left_level  = side_level[mix_pkg::SIDE_LEFT];
    assign right_level = side_level[mix_pkg::SIDE_RIGHT];

    AST_SLOT_CLEAR: assert property (@(posedge clk)
        rst |=> slot_idx == '0); // R1
endmodule

// File: tb/stereo_slot_mixer_test.sv
module stereo_slot_mixer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_adv = 1'b0;
    logic [3:0] src_bits = '0;
    logic [1:0] dac_mode = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] left_level, right_level;
    logic [1:0] slot_idx;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    int m_amp [2][4];
    int m_lvl [2];
    int m_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_slot_mixer uut (
        .clk(clk), .rst(rst), .slot_adv(slot_adv), .src_bits(src_bits),
        .dac_mode(dac_mode), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .left_level(left_level), .right_level(right_level), .slot_idx(slot_idx)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic void model_edge();
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                m_lvl[s] = 0;
                for (int k = 0; k < 4; k++) m_amp[s][k] = 0;
            end
            m_slot = 0;
        end else begin
            if (slot_adv) begin
                int ns;
                ns = (m_slot + 1) % 4;
                for (int s = 0; s < 2; s++) begin
                    if (dac_mode[s])      m_lvl[s] = m_amp[s][0];
                    else if (src_bits[ns]) m_lvl[s] = m_amp[s][ns];
                    else                  m_lvl[s] = 0;
                end
                m_slot = ns;
            end
            if (wr_en && wr_idx >= 8)
                m_amp[(int'(wr_idx) - 8) / 4][int'(wr_idx) % 4] = int'(wr_data) % 64;
        end
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, int'(left_level),  m_lvl[0], "left_level");
        check(tag, int'(right_level), m_lvl[1], "right_level");
        check(tag, int'(slot_idx),    m_slot,   "slot_idx");
        slot_adv = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic write_reg(input int idx, input int data, input string tag);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = 8'(data);
        step(tag);
    endtask

    task automatic boundary(input logic [3:0] src, input string tag);
        src_bits = src; slot_adv = 1'b1;
        step(tag);
    endtask

    initial begin
        // R1: reset state
        step("R1");
        step("R1");
        rst = 1'b0;
        step("R1");

        // R3, R9: load both banks, upper data bits set on some; R8: no boundary yet
        write_reg(8,  8'hC0 | 11, "R8");
        write_reg(9,  22, "R8");
        write_reg(10, 8'h40 | 33, "R9");
        write_reg(11, 44, "R8");
        write_reg(12, 5, "R3");
        write_reg(13, 8'h80 | 6, "R9");
        write_reg(14, 7, "R3");
        write_reg(15, 63, "R3");

        // R4: writes to low indices must not disturb amplitudes
        for (int i = 0; i < 8; i++) write_reg(i, 8'h2A + i, "R4");

        // R5, R2: all sources high, two full rotations
        for (int i = 0; i < 8; i++) boundary(4'hF, "R5");
        // R6: all sources low
        for (int i = 0; i < 4; i++) boundary(4'h0, "R6");
        // R5/R6 mixed patterns, boundaries every other cycle (R8 hold)
        for (int i = 0; i < 12; i++) begin
            boundary(4'((i * 5 + 3) % 16), "R5");
            src_bits = 4'((i * 7) % 16);
            step("R8");
        end

        // R7: left DAC mode, then right, then both
        dac_mode = 2'b01;
        for (int i = 0; i < 4; i++) boundary(4'((i * 3) % 16), "R7");
        dac_mode = 2'b10;
        for (int i = 0; i < 4; i++) boundary(4'h5, "R7");
        dac_mode = 2'b11;
        for (int i = 0; i < 4; i++) boundary(4'h0, "R7");
        dac_mode = 2'b00;

        // R8: write between boundaries, and a write coincident with a boundary
        write_reg(8, 50, "R8");
        step("R8");
        boundary(4'hF, "R8");
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 8'd17;
        boundary(4'hF, "R8");
        for (int i = 0; i < 6; i++) boundary(4'hF, "R8");

        // R1: reset mid-run
        rst = 1'b1;
        step("R1");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) boundary(4'hF, "R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule